// File: doc/BRIEF.md
# Serial Memory Write Guard

This block sits beside the command decoder of a small serial non-volatile memory and answers one question for every modification request: may it go ahead? It holds the protection part of the status byte: a lock-enable bit, a two-bit region selector and a volatile write-enable latch. It combines these with the active-low write-protect pin and the busy flag of the write engine. The answer comes back as a status-update grant or an array-write grant.

The decoder sends single-cycle strobes for "enable writes", "disable writes", "status write" (with its data byte) and "array write commit" (with its address). A granted status write does not change the visible bits at once. The new value is held and is copied in when the write engine pulses its cycle-done input, which is how a self-timed program cycle behaves. The status byte for reads is built here too. While the engine is busy, it reads as all ones.

Top module: `wp_guard`

## Requirements
- R1: With busy low, the status byte reads as {lock-enable at bit 7, 0 at bits 6..4, region selector at bits 3..2, write-enable at bit 1, 0 at bit 0}. After reset it is 0x00.
- R2: Bits 6..4 of a status-write data byte are dropped and always read back as 0.
- R3: While busy is high, the status byte reads 0xFF.
- R4: For a 10-bit address, the region selector protects: 00 nothing, 01 addresses 0x300..0x3FF, 10 addresses 0x200..0x3FF, 11 the whole array.
- R5: An array write to a protected address is never granted, whatever the write-enable latch, the lock-enable bit or the pin.
- R6: The write-enable latch is 0 after reset and goes to 1 only on the next clock after an enable strobe taken while idle.
- R7: The write-enable latch is 0 on the clock after a disable strobe, a status-write strobe or an array-write strobe taken while idle, granted or not. A disable strobe beats an enable strobe in the same cycle.
- R8: While the write-enable latch is 0, no status write and no array write is granted.
- R9: When the pin is low and the lock-enable bit is 1, status writes are refused. Array grants do not depend on the pin.
- R10: A status write that clears a set lock-enable bit is granted only while the pin is high.
- R11: A granted status write changes bits 7 and 3..2 only on the clock after the cycle-done pulse. Before that pulse they keep their old value. A pulse with nothing held changes nothing.
- R12: While busy is high, every strobe is ignored: no grant, and the write-enable latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| set_en_i | input | 1 | Enable-writes strobe |
| clr_en_i | input | 1 | Disable-writes strobe |
| sr_wr_i | input | 1 | Status-write strobe |
| sr_wdata_i | input | 8 | Data byte of the status write |
| arr_wr_i | input | 1 | Array-write commit strobe |
| arr_addr_i | input | ADDR_W | Array address of the commit |
| busy_i | input | 1 | Write engine busy |
| cycle_done_i | input | 1 | Write-cycle-done pulse |
| status_o | output | 8 | Status byte for reads |
| sr_allow_o | output | 1 | Status write granted |
| arr_allow_o | output | 1 | Array write granted |

## Verification
The bench probes the edges of each protected region: 0x2FF against 0x300 and 0x1FF against 0x200. A decoder with an off-by-one boundary, or with the quarter and half codes swapped, would grant or refuse the wrong one of each pair. It checks that a refused status write still clears the write-enable latch, and that a write held for staging stays invisible until cycle-done. A design that applies the value at the strobe would show the new region selector one step early. It also drives the pin low with the lock-enable bit set, to show that status writes are blocked while array writes still pass. Finally it raises busy together with strobes. A design that let commands through during a write cycle would change the latch or grant a write.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

   // bit positions of the status byte (read side depends on them)
   localparam int SR_W      = 8;
   localparam int SR_LOCKEN = 7;
   localparam int SR_RG_HI  = 3;
   localparam int SR_RG_LO  = 2;
   localparam int SR_WEN    = 1;

   typedef struct packed {
      logic       locken;
      logic [1:0] region;
   } wp_prot_t;

   function automatic logic [SR_W-1:0] wp_pack_status(wp_prot_t p, logic wen);
      logic [SR_W-1:0] s;
      s            = '0;
      s[SR_LOCKEN] = p.locken;
      s[SR_RG_HI]  = p.region[1];
      s[SR_RG_LO]  = p.region[0];
      s[SR_WEN]    = wen;
      return s;
   endfunction

endpackage

// File: rtl/wp_wen_latch.sv
module wp_wen_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic sr_req_i,
   input  logic arr_req_i,
   output logic wen_o
);

   logic drop_c;
   logic raise_c;

   // any write-type request ends the enable window, granted or not
   assign drop_c  = !busy_i && (clr_i || sr_req_i || arr_req_i);
   assign raise_c = !busy_i && set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wen_o <= 1'b0;
      else if (drop_c)  wen_o <= 1'b0;
      else if (raise_c) wen_o <= 1'b1;
   end

endmodule

// File: rtl/wp_stat_stage.sv
module wp_stat_stage
   import wp_guard_pkg::*;
#(
   parameter logic       RST_LOCKEN = 1'b0,
   parameter logic [1:0] RST_REGION = 2'b00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept_i,
   input  logic [SR_W-1:0] wdata_i,
   input  logic            done_i,
   output wp_prot_t        prot_o
);

   localparam wp_prot_t RST_PROT = '{locken: RST_LOCKEN, region: RST_REGION};

   wp_prot_t hold_q;
   logic     hold_vld_q;
   wp_prot_t new_c;
   logic     unused_bits;

   assign new_c.locken = wdata_i[SR_LOCKEN];
   assign new_c.region = wdata_i[SR_RG_HI:SR_RG_LO];
   assign unused_bits  = ^{wdata_i[6:4], wdata_i[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= RST_PROT;
         hold_vld_q <= 1'b0;
      end else if (accept_i) begin
         hold_q     <= new_c;
         hold_vld_q <= 1'b1;
      end else if (done_i) begin
         hold_vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   prot_o <= RST_PROT;
      else if (done_i && hold_vld_q) prot_o <= hold_q;
   end

endmodule

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
   parameter int ADDR_W = 10
) (
   input  logic [1:0]        region_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   localparam int TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wp_region_chk: ADDR_W must be at least 2");
      end
   endgenerate

   logic top_quarter;
   logic top_half;

   assign top_quarter = (addr_i[TOP -: 2] == 2'b11);
   assign top_half    = addr_i[TOP];

   always_comb begin
      unique case (region_i)
         2'b00:   hit_o = 1'b0;
         2'b01:   hit_o = top_quarter;
         2'b10:   hit_o = top_half;
         default: hit_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wp_guard_pkg::*;
#(
   parameter int         ADDR_W     = 10,
   parameter logic       RST_LOCKEN = 1'b0,
   parameter logic [1:0] RST_REGION = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic              set_en_i,
   input  logic              clr_en_i,
   input  logic              sr_wr_i,
   input  logic [7:0]        sr_wdata_i,
   input  logic              arr_wr_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   input  logic              busy_i,
   input  logic              cycle_done_i,
   output logic [7:0]        status_o,
   output logic              sr_allow_o,
   output logic              arr_allow_o
);

   generate
      if (SR_W != 8) begin : g_bad_sr
         $error("wp_guard: status byte must be 8 bits");
      end
   endgenerate

   logic     wen;
   logic     hw_lock;
   logic     prot_hit;
   wp_prot_t prot;

   wp_wen_latch u_wen (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy_i),
      .set_i     (set_en_i),
      .clr_i     (clr_en_i),
      .sr_req_i  (sr_wr_i),
      .arr_req_i (arr_wr_i),
      .wen_o     (wen)
   );

   wp_stat_stage #(
      .RST_LOCKEN (RST_LOCKEN),
      .RST_REGION (RST_REGION)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (sr_allow_o),
      .wdata_i  (sr_wdata_i),
      .done_i   (cycle_done_i),
      .prot_o   (prot)
   );

   wp_region_chk #(.ADDR_W(ADDR_W)) u_region (
      .region_i (prot.region),
      .addr_i   (arr_addr_i),
      .hit_o    (prot_hit)
   );

   // pin lock: only the status byte is frozen, never the array
   assign hw_lock     = !wp_n_i && prot.locken;
   assign sr_allow_o  = sr_wr_i  && !busy_i && wen && !hw_lock;
   assign arr_allow_o = arr_wr_i && !busy_i && wen && !prot_hit;
   assign status_o    = busy_i ? {SR_W{1'b1}} : wp_pack_status(prot, wen);

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_n_i,
   input logic              set_en_i,
   input logic              clr_en_i,
   input logic              sr_wr_i,
   input logic [7:0]        sr_wdata_i,
   input logic              arr_wr_i,
   input logic [ADDR_W-1:0] arr_addr_i,
   input logic              busy_i,
   input logic              cycle_done_i,
   input logic [7:0]        status_o,
   input logic              sr_allow_o,
   input logic              arr_allow_o
);

   // R1
   idle_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));

   // R2
   unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !$past(busy_i) && $past(sr_allow_o) && ($past(sr_wdata_i[6:4]) != 3'b000))
      |-> (status_o[6:4] == 3'b000));

   // R3
   busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (status_o == 8'hFF));

   // R4 R5
   region_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_allow_o |-> (status_o[3:2] != 2'b11
                       && !(status_o[3:2] == 2'b10 && arr_addr_i[ADDR_W-1])
                       && !(status_o[3:2] == 2'b01 && arr_addr_i[ADDR_W-1 -: 2] == 2'b11)));

   // R6
   wen_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !$past(busy_i) && status_o[1] && !$past(status_o[1])) |-> $past(set_en_i));

   // R7
   wen_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!busy_i && (clr_en_i || sr_wr_i || arr_wr_i)) && !busy_i) |-> !status_o[1]);

   // R8
   wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !status_o[1]) |-> (!sr_allow_o && !arr_allow_o));

   // R9
   pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !wp_n_i && status_o[7]) |-> !sr_allow_o);

   // R10
   locken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_allow_o && status_o[7] && !sr_wdata_i[7]) |-> wp_n_i);

   // R11
   staged_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !$past(busy_i) && !$past(cycle_done_i))
      |-> ($stable(status_o[7]) && $stable(status_o[3:2])));

   // R12
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (!sr_allow_o && !arr_allow_o));

   // R12
   grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_allow_o |-> sr_wr_i) and (arr_allow_o |-> arr_wr_i));

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wp_n_i       (wp_n_i),
   .set_en_i     (set_en_i),
   .clr_en_i     (clr_en_i),
   .sr_wr_i      (sr_wr_i),
   .sr_wdata_i   (sr_wdata_i),
   .arr_wr_i     (arr_wr_i),
   .arr_addr_i   (arr_addr_i),
   .busy_i       (busy_i),
   .cycle_done_i (cycle_done_i),
   .status_o     (status_o),
   .sr_allow_o   (sr_allow_o),
   .arr_allow_o  (arr_allow_o)
);

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 10;
   localparam int NROW   = 35;

   // command codes used by the table
   localparam logic [2:0] C_NONE = 3'd0;
   localparam logic [2:0] C_SET  = 3'd1;
   localparam logic [2:0] C_CLR  = 3'd2;
   localparam logic [2:0] C_SRW  = 3'd3;
   localparam logic [2:0] C_ARW  = 3'd4;
   localparam logic [2:0] C_DONE = 3'd5;

   // {req[3:0], cmd[2:0], wp_n, busy, arg[9:0], exp_grant, exp_status_after[7:0]}
   localparam logic [27:0] VEC [NROW] = '{
      {4'd8,  C_ARW,  1'b1, 1'b0, 10'h000, 1'b0, 8'h00}, // R8 no latch, no grant
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h02}, // R6
      {4'd7,  C_ARW,  1'b1, 1'b0, 10'h000, 1'b1, 8'h00}, // R7 granted write clears latch
      {4'd8,  C_SRW,  1'b1, 1'b0, 10'h08C, 1'b0, 8'h00}, // R8
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h02}, // R6
      {4'd11, C_SRW,  1'b1, 1'b0, 10'h084, 1'b1, 8'h00}, // R11 held, not visible
      {4'd11, C_DONE, 1'b1, 1'b0, 10'h000, 1'b0, 8'h84}, // R11 applied
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h86}, // R6
      {4'd4,  C_ARW,  1'b1, 1'b0, 10'h300, 1'b0, 8'h84}, // R4 quarter edge denied
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h86}, // R6
      {4'd4,  C_ARW,  1'b1, 1'b0, 10'h2FF, 1'b1, 8'h84}, // R4 below quarter granted
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h86}, // R6
      {4'd9,  C_SRW,  1'b0, 1'b0, 10'h000, 1'b0, 8'h84}, // R9 pin lock, R7 refused clears
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h86}, // R6
      {4'd9,  C_ARW,  1'b0, 1'b0, 10'h001, 1'b1, 8'h84}, // R9 array unaffected by pin
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h86}, // R6
      {4'd10, C_SRW,  1'b1, 1'b0, 10'h078, 1'b1, 8'h84}, // R10 clear lock-enable, pin high
      {4'd2,  C_DONE, 1'b1, 1'b0, 10'h000, 1'b0, 8'h08}, // R2 bits 6..4 dropped
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0A}, // R6
      {4'd4,  C_ARW,  1'b1, 1'b0, 10'h200, 1'b0, 8'h08}, // R4 half edge denied
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0A}, // R6
      {4'd4,  C_ARW,  1'b1, 1'b0, 10'h1FF, 1'b1, 8'h08}, // R4 below half granted
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0A}, // R6
      {4'd7,  C_CLR,  1'b1, 1'b0, 10'h000, 1'b0, 8'h08}, // R7 disable strobe
      {4'd8,  C_ARW,  1'b1, 1'b0, 10'h000, 1'b0, 8'h08}, // R8
      {4'd12, C_SET,  1'b1, 1'b1, 10'h000, 1'b0, 8'h08}, // R12 enable ignored while busy
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0A}, // R6
      {4'd11, C_SRW,  1'b1, 1'b0, 10'h00C, 1'b1, 8'h08}, // R11
      {4'd11, C_DONE, 1'b1, 1'b0, 10'h000, 1'b0, 8'h0C}, // R11
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0E}, // R6
      {4'd5,  C_ARW,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0C}, // R5 whole array protected
      {4'd11, C_DONE, 1'b1, 1'b0, 10'h000, 1'b0, 8'h0C}, // R11 empty pulse
      {4'd6,  C_SET,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0E}, // R6
      {4'd12, C_SRW,  1'b1, 1'b1, 10'h000, 1'b0, 8'h0E}, // R12 latch kept while busy
      {4'd7,  C_CLR,  1'b1, 1'b0, 10'h000, 1'b0, 8'h0C}  // R7
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_n_i = 1'b1;
   logic              set_en_i = 1'b0;
   logic              clr_en_i = 1'b0;
   logic              sr_wr_i = 1'b0;
   logic [7:0]        sr_wdata_i = 8'h00;
   logic              arr_wr_i = 1'b0;
   logic [ADDR_W-1:0] arr_addr_i = '0;
   logic              busy_i = 1'b0;
   logic              cycle_done_i = 1'b0;
   logic [7:0]        status_o;
   logic              sr_allow_o;
   logic              arr_allow_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   wp_guard #(.ADDR_W(ADDR_W)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wp_n_i       (wp_n_i),
      .set_en_i     (set_en_i),
      .clr_en_i     (clr_en_i),
      .sr_wr_i      (sr_wr_i),
      .sr_wdata_i   (sr_wdata_i),
      .arr_wr_i     (arr_wr_i),
      .arr_addr_i   (arr_addr_i),
      .busy_i       (busy_i),
      .cycle_done_i (cycle_done_i),
      .status_o     (status_o),
      .sr_allow_o   (sr_allow_o),
      .arr_allow_o  (arr_allow_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      set_en_i = 1'b0; clr_en_i = 1'b0; sr_wr_i = 1'b0; arr_wr_i = 1'b0;
      cycle_done_i = 1'b0; busy_i = 1'b0; wp_n_i = 1'b1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset status", status_o, 8'h00);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 idle after reset", status_o, 8'h00);

      for (int i = 0; i < NROW; i++) begin
         logic [3:0] rq;
         logic [2:0] cmd;
         logic       grant_exp;
         rq        = VEC[i][27:24];
         cmd       = VEC[i][23:21];
         grant_exp = VEC[i][8];
         @(negedge clk);
         wp_n_i       = VEC[i][20];
         busy_i       = VEC[i][19];
         set_en_i     = (cmd == C_SET);
         clr_en_i     = (cmd == C_CLR);
         sr_wr_i      = (cmd == C_SRW);
         arr_wr_i     = (cmd == C_ARW);
         cycle_done_i = (cmd == C_DONE);
         sr_wdata_i   = VEC[i][16:9];
         arr_addr_i   = VEC[i][18:9];
         #1;
         check($sformatf("R%0d row %0d status-grant", rq, i),
               {7'b0, sr_allow_o}, {7'b0, (cmd == C_SRW) && grant_exp});
         check($sformatf("R%0d row %0d array-grant", rq, i),
               {7'b0, arr_allow_o}, {7'b0, (cmd == C_ARW) && grant_exp});
         if (VEC[i][19]) check("R3 busy readout", status_o, 8'hFF);
         @(negedge clk);
         idle_inputs();
         #1;
         check($sformatf("R%0d row %0d status after", rq, i), status_o, VEC[i][7:0]);
      end

      // R7 disable beats enable in the same cycle
      @(negedge clk);
      set_en_i = 1'b1; clr_en_i = 1'b1;
      @(negedge clk);
      idle_inputs(); #1;
      check("R7 clear over set", status_o, 8'h0C);

      // R1 reset brings region and lock-enable back to default
      @(negedge clk);
      rst_n = 1'b0; #1;
      check("R1 re-reset status", status_o, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R4 region cleared after reset", status_o, 8'h00);

      finish_run();
   end

endmodule